// File: doc/BRIEF.md
# DMA Channel Run Gate and Vectored Interrupt Unit

This block sits beside a byte-transfer DMA channel and decides, on every clock, whether that channel may run. It takes the programmed command field, the channel enable, the operating mode, a ready-polarity setting and the external ready line. It also takes two sticky status flags: one for a search hit (match) and one for the end of the block. From these it produces a registered `working` level and a one-cycle `start_pulse` that marks each time the channel begins to run.

The same block builds the vectored interrupt for an 8-bit CPU that accepts a vector during its acknowledge cycle. A pending cause raises `irq_req`, and the request stays up until the CPU acknowledges it. On the acknowledge cycle the vector is driven. That vector is either the stored base vector unchanged, or the base vector with bits 2:1 replaced by a code for the interrupt cause. The flags and registers arrive as plain inputs; the transfer engine and the search comparator live elsewhere.

Top module: `dma_activity_irq`

## Requirements
- R1: One clock after an edge at which the command field is nonzero, `chan_en` is 1 and `end_flag` is 0 (and R2, R3 and R4 do not block), `working` is 1. One clock after an edge where any of those conditions fails, `working` is 0.
- R2: When command bit 1 (the search bit) is 1 and `match_flag` is 1, the channel does not work. With command bit 1 at 0, `match_flag` has no effect on `working`.
- R3: In every mode except mode 1, the channel works only when `rdy_pol` equals the not-ready bit, which is the inverse of `ext_ready`. In mode 1, `rdy_pol` and `ext_ready` levels have no effect (except through R4).
- R4: At a clock edge where `ext_ready` is 0 and was 1 at the previous edge, `working` goes to 0 after that edge, whatever the mode. At the following edges the full condition applies again.
- R5: `start_pulse` is 1 for exactly the cycle in which `working` has just risen from 0 to 1, and 0 otherwise.
- R6: A new request is raised only while `irq_en` is 1. The match cause needs `irq_ctrl[0]` and `match_flag`, and it gives code 2. The end cause needs `irq_ctrl[1]` and `end_flag`, and it gives code 4. When both are present, match wins.
- R7: When `irq_ctrl[5]` is 1, the vector is (`irq_base` AND 0xF9) plus the cause code. Otherwise it is `irq_base` unchanged. The vector is captured at the edge where the request is raised.
- R8: `irq_req` stays 1 until an edge with `irq_ack` at 1, and it is 0 after that edge. A new request can be raised at the next edge. `irq_vector` shows the captured vector only while `irq_req` and `irq_ack` are both 1, and is 0 at all other times.
- R9: While `rst` is 1 and after it, `working`, `start_pulse` and `irq_req` are 0 until inputs make them otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Command field; bit 1 selects search |
| chan_en | input | 1 | Channel enable |
| op_mode | input | 2 | Operating mode; mode 1 skips the ready compare |
| rdy_pol | input | 1 | Ready polarity setting compared with the not-ready bit |
| ext_ready | input | 1 | External ready line, high when ready |
| match_flag | input | 1 | Sticky search-match status |
| end_flag | input | 1 | Sticky end-of-block status |
| irq_en | input | 1 | Interrupt enable |
| irq_ctrl | input | 8 | Interrupt control: bit 0 on match, bit 1 on end, bit 5 status affects vector |
| irq_base | input | 8 | Stored base vector |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| working | output | 1 | Registered run permission |
| start_pulse | output | 1 | One-cycle pulse when working rises |
| irq_req | output | 1 | Interrupt request, held until acknowledged |
| irq_vector | output | 8 | Vector, driven during the acknowledge cycle |

## Verification
The bound assertions check on every cycle these rules: `working` implies that the command, enable and end-flag conditions held one edge earlier; a falling ready line clears `working`; `start_pulse` matches the rising edge of `working`; a request is held until acknowledged and only starts while interrupts are enabled; and the vector bus stays at zero outside acknowledge. The bench's scenarios are needed to show the value of the status-modified vector, the match-over-end priority, and that mode 1 skips the polarity compare. They also show that `working` returns one cycle after a ready drop, and they cover the long mixed sequences that the reference model follows cycle by cycle.

// File: rtl/dma_act_pkg.sv
package dma_act_pkg;
  localparam int CMD_W      = 2;
  localparam int MODE_W     = 2;
  localparam int CTRL_W     = 8;
  localparam int VEC_W      = 8;
  // control bit positions decoded by the interrupt unit
  localparam int CTL_ON_MATCH = 0;
  localparam int CTL_ON_END   = 1;
  localparam int CTL_STATUS   = 5;
  // cause code occupies vector bits 2:1
  localparam int CODE_LSB   = 1;
  localparam int CODE_W     = 2;

  typedef enum logic [CODE_W-1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_MATCH = 2'b01,
    CAUSE_END   = 2'b10
  } irq_cause_e;
endpackage

// File: rtl/dma_run_gate.sv
module dma_run_gate
  import dma_act_pkg::*;
#(
  parameter int BYPASS_MODE = 1
) (
  input  logic [CMD_W-1:0]  cmd,
  input  logic              chan_en,
  input  logic [MODE_W-1:0] op_mode,
  input  logic              rdy_pol,
  input  logic              ext_ready,
  input  logic              match_flag,
  input  logic              end_flag,
  output logic              run_ok
);
  logic not_ready;
  logic pol_ok;
  logic search_hit;

  always_comb begin
    not_ready  = ~ext_ready;
    pol_ok     = (op_mode == MODE_W'(BYPASS_MODE)) || (rdy_pol == not_ready);
    search_hit = cmd[CMD_W-1] & match_flag;
    run_ok     = (|cmd) & chan_en & ~end_flag & ~search_hit & pol_ok;
  end
endmodule

// File: rtl/dma_run_reg.sv
module dma_run_reg (
  input  logic clk,
  input  logic rst,
  input  logic run_ok,
  input  logic ext_ready,
  output logic working,
  output logic start_pulse
);
  logic ready_q;
  logic ready_drop;
  logic run_next;

  // plain sample of the ready line; valid after the first edge in reset
  always_ff @(posedge clk) ready_q <= ext_ready;

  always_comb begin
    ready_drop = ready_q & ~ext_ready;
    run_next   = run_ok & ~ready_drop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      working     <= 1'b0;
      start_pulse <= 1'b0;
    end else begin
      working     <= run_next;
      start_pulse <= run_next & ~working;
    end
  end
endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
  import dma_act_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_en,
  input  logic [CTRL_W-1:0] irq_ctrl,
  input  logic [VEC_W-1:0]  irq_base,
  input  logic              match_flag,
  input  logic              end_flag,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vector
);
  localparam logic [VEC_W-1:0] CODE_MASK = VEC_W'(((1 << CODE_W) - 1) << CODE_LSB);

  irq_cause_e       cause;
  logic [VEC_W-1:0] vec_next;
  logic [VEC_W-1:0] vec_q;

  always_comb begin
    cause = CAUSE_NONE;
    if (irq_en) begin
      if (irq_ctrl[CTL_ON_MATCH] && match_flag)   cause = CAUSE_MATCH;
      else if (irq_ctrl[CTL_ON_END] && end_flag)  cause = CAUSE_END;
    end
    if (irq_ctrl[CTL_STATUS])
      vec_next = (irq_base & ~CODE_MASK) | (VEC_W'(cause) << CODE_LSB);
    else
      vec_next = irq_base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      vec_q   <= '0;
    end else if (irq_req) begin
      if (irq_ack) irq_req <= 1'b0;
    end else if (cause != CAUSE_NONE) begin
      irq_req <= 1'b1;
      vec_q   <= vec_next;
    end
  end

  assign irq_vector = (irq_req && irq_ack) ? vec_q : '0;
endmodule

// File: rtl/dma_activity_irq.sv
module dma_activity_irq
  import dma_act_pkg::*;
#(
  parameter int BYPASS_MODE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              chan_en,
  input  logic [MODE_W-1:0] op_mode,
  input  logic              rdy_pol,
  input  logic              ext_ready,
  input  logic              match_flag,
  input  logic              end_flag,
  input  logic              irq_en,
  input  logic [CTRL_W-1:0] irq_ctrl,
  input  logic [VEC_W-1:0]  irq_base,
  input  logic              irq_ack,
  output logic              working,
  output logic              start_pulse,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vector
);
  logic run_ok;

  dma_run_gate #(.BYPASS_MODE(BYPASS_MODE)) u_gate (
    .cmd(cmd), .chan_en(chan_en), .op_mode(op_mode), .rdy_pol(rdy_pol),
    .ext_ready(ext_ready), .match_flag(match_flag), .end_flag(end_flag),
    .run_ok(run_ok)
  );

  dma_run_reg u_run (
    .clk(clk), .rst(rst), .run_ok(run_ok), .ext_ready(ext_ready),
    .working(working), .start_pulse(start_pulse)
  );

  dma_irq_unit u_irq (
    .clk(clk), .rst(rst), .irq_en(irq_en), .irq_ctrl(irq_ctrl),
    .irq_base(irq_base), .match_flag(match_flag), .end_flag(end_flag),
    .irq_ack(irq_ack), .irq_req(irq_req), .irq_vector(irq_vector)
  );
endmodule

// File: rtl/dma_activity_irq_chk.sv
module dma_activity_irq_chk
  import dma_act_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [CMD_W-1:0]  cmd,
  input logic              chan_en,
  input logic              end_flag,
  input logic              ext_ready,
  input logic              irq_en,
  input logic              irq_ack,
  input logic              working,
  input logic              start_pulse,
  input logic              irq_req,
  input logic [VEC_W-1:0]  irq_vector
);
  // R1
  work_needs_setup_chk: assert property (@(posedge clk) disable iff (rst)
    working |-> $past(cmd != '0 && chan_en && !end_flag));
  // R4
  ready_drop_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ext_ready) |=> !working);
  // R5
  start_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(working) |-> start_pulse);
  // R5
  start_only_rise_chk: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> working && !$past(working));
  // R8
  req_held_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req && !irq_ack |=> irq_req);
  // R8
  req_released_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req && irq_ack |=> !irq_req);
  // R6
  req_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(irq_en));
  // R8
  vec_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !(irq_req && irq_ack) |-> irq_vector == '0);
endmodule

bind dma_activity_irq dma_activity_irq_chk u_chk (
  .clk(clk), .rst(rst), .cmd(cmd), .chan_en(chan_en), .end_flag(end_flag),
  .ext_ready(ext_ready), .irq_en(irq_en), .irq_ack(irq_ack),
  .working(working), .start_pulse(start_pulse), .irq_req(irq_req),
  .irq_vector(irq_vector)
);

// File: tb/test_dma_activity_irq.sv
`timescale 1ns/1ps
module test_dma_activity_irq;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] cmd;
  logic       chan_en;
  logic [1:0] op_mode;
  logic       rdy_pol;
  logic       ext_ready;
  logic       match_flag;
  logic       end_flag;
  logic       irq_en;
  logic [7:0] irq_ctrl;
  logic [7:0] irq_base;
  logic       irq_ack;
  logic       working;
  logic       start_pulse;
  logic       irq_req;
  logic [7:0] irq_vector;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  dma_activity_irq i_dma_activity_irq (.*);

  // behavioural reference model
  bit       m_prev_rdy;
  bit       m_work, m_start, m_req;
  bit [7:0] m_vec;

  always @(posedge clk) begin
    bit cond, drop, nw;
    int code;
    drop = m_prev_rdy && !ext_ready;
    m_prev_rdy = ext_ready;
    cond = (cmd != 0) && chan_en && !end_flag && !(cmd[1] && match_flag)
           && (op_mode == 1 || rdy_pol == !ext_ready);
    code = 0;
    if (irq_en && irq_ctrl[0] && match_flag) code = 2;
    else if (irq_en && irq_ctrl[1] && end_flag) code = 4;
    if (rst) begin
      m_work = 0; m_start = 0; m_req = 0; m_vec = 0;
    end else begin
      nw = drop ? 0 : cond;
      m_start = nw && !m_work;
      m_work = nw;
      if (m_req) begin
        if (irq_ack) m_req = 0;
      end else if (code != 0) begin
        m_req = 1;
        m_vec = irq_ctrl[5] ? ((irq_base & 8'hF9) + 8'(code)) : irq_base;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("R1 R2 R3 R4 R9 working", working, m_work);
    chk("R5 start_pulse", start_pulse, m_start);
    chk("R6 R8 irq_req", irq_req, m_req);
    chk("R7 R8 irq_vector", irq_vector, (m_req && irq_ack) ? m_vec : 0);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit [15:0] lfsr;
    rst = 1; cmd = 0; chan_en = 0; op_mode = 0; rdy_pol = 0; ext_ready = 1;
    match_flag = 0; end_flag = 0; irq_en = 0; irq_ctrl = 0; irq_base = 0; irq_ack = 0;
    cyc(3);
    // R9 reset state
    chk("R9 reset working", working, 0);
    chk("R9 reset irq_req", irq_req, 0);
    rst = 0;
    // R1 basic run, then stop on each missing condition
    cmd = 2'b01; chan_en = 1; cyc(3);
    chk("R1 runs", working, 1);
    cmd = 0; cyc(2);
    chk("R1 cmd zero stops", working, 0);
    cmd = 2'b11; end_flag = 1; cyc(2);
    chk("R1 end flag stops", working, 0);
    end_flag = 0; chan_en = 0; cyc(2);
    chk("R1 disable stops", working, 0);
    chan_en = 1; cyc(2);
    // R2 search with match stops, transfer-only ignores match
    cmd = 2'b10; match_flag = 1; cyc(2);
    chk("R2 search match stops", working, 0);
    cmd = 2'b01; cyc(2);
    chk("R2 no search ignores match", working, 1);
    match_flag = 0;
    // R3 polarity compare in mode 0, skipped in mode 1
    rdy_pol = 1; cyc(2);
    chk("R3 polarity mismatch stops", working, 0);
    op_mode = 1; cyc(2);
    chk("R3 mode 1 ignores polarity", working, 1);
    // R4 ready drop forces a one-cycle stop in mode 1
    ext_ready = 0; cyc(1);
    chk("R4 ready drop stops", working, 0);
    cyc(1);
    chk("R4 recovers", working, 1);
    ext_ready = 1; op_mode = 0; rdy_pol = 0; cyc(3);
    // R6 no request while disabled
    irq_ctrl = 8'h03; match_flag = 1; end_flag = 1; cyc(3);
    chk("R6 disabled no request", irq_req, 0);
    // R6 R7 match priority, status-modified vector
    irq_base = 8'hFF; irq_ctrl = 8'h23; irq_en = 1; cyc(1);
    irq_en = 0; cyc(2);
    chk("R8 held", irq_req, 1);
    irq_ack = 1; #0.5;
    chk("R7 match vector", irq_vector, 8'hFB);
    cyc(1); irq_ack = 0;
    chk("R8 released", irq_req, 0);
    // R6 R7 end cause, modified
    match_flag = 0; irq_en = 1; cyc(1); irq_en = 0;
    irq_ack = 1; #0.5;
    chk("R7 end vector", irq_vector, 8'hFD);
    cyc(1); irq_ack = 0;
    // R7 unmodified vector
    irq_ctrl = 8'h02; irq_base = 8'h5A; irq_en = 1; cyc(1); irq_en = 0;
    irq_ack = 1; #0.5;
    chk("R7 plain vector", irq_vector, 8'h5A);
    cyc(1); irq_ack = 0; end_flag = 0;
    // mixed pseudo-random run against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cmd = lfsr[1:0]; chan_en = lfsr[2] | lfsr[3]; op_mode = lfsr[5:4];
      rdy_pol = lfsr[6] & lfsr[7]; ext_ready = lfsr[8] | lfsr[9];
      match_flag = lfsr[10] & lfsr[11]; end_flag = lfsr[12] & lfsr[13];
      irq_en = lfsr[14]; irq_ctrl = {2'b00, lfsr[15], 3'b000, lfsr[3], lfsr[7]};
      irq_base = lfsr[15:8] ^ lfsr[7:0]; irq_ack = lfsr[1] & lfsr[9];
      cyc(1);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule